// File: doc/BRIEF.md
# Prioritized Memory Bank Address Decoder

This block decides which programmable memory bank serves a bus cycle. It holds a small table of banks. Each bank has a base address, an address mask that sets its size, a valid bit and an owner bit. The owner bit says whether the system bus or the local bus owns the bank. A request arrives with a strobe, a 32-bit address and a tag giving the bus it came from. The block compares the address against every bank at once and resolves the result one clock later. The result is a hit flag, a bank index, a forward-to-local flag and a miss flag.

Where banks overlap, the lowest index wins. The owner bits change the result. A system-bus request that lands on a local-owned bank is passed on to the local bus, and that outcome wins over any ordinary hit. A local-bus request that lands only on system-owned banks is dropped. The miss flag lets a default or error responder take over any request that did not hit.

Top module: `bank_addr_decoder`

## Requirements
- R1: The outputs are registered. They reflect the request whose strobe was high at the previous rising clock edge. After a cycle with no strobe, hit, bank, forward and miss are all zero.
- R2: A bank matches when its valid bit is 1 and (address AND mask) equals (base AND mask). A bank with the valid bit at 0 never matches, even when its mask is all zeros.
- R3: When several candidate banks match, the bank with the lowest index is reported.
- R4: A system request (origin 0) that matches a local-owned bank (owner 1) gives hit=1, forward=1 and the index of that bank.
- R5: For a system request, a match on a local-owned bank takes precedence over a match on a system-owned bank, even one with a lower index.
- R6: A local request (origin 1) ignores system-owned banks. If it matches only system-owned banks it gives no hit. If it matches a local-owned bank it gives hit=1 with forward=0.
- R7: A strobed request with no hit gives miss=1. Hit and miss are never 1 together.
- R8: A table write takes effect for requests from the next cycle on. A request in the same cycle as a write is decoded against the old table. Reset clears every valid bit.
- R9: The bank index is zero whenever hit is 0. Forward is 1 only together with hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one bank table entry |
| cfg_idx | input | 3 | Index of the bank entry to write |
| cfg_base | input | 32 | Base address to store |
| cfg_mask | input | 32 | Address mask to store (ones are compared bits) |
| cfg_valid | input | 1 | Valid bit to store |
| cfg_owner | input | 1 | Owner to store: 0 system bus, 1 local bus |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request address |
| req_from_local | input | 1 | Request origin: 0 system bus, 1 local bus |
| dec_hit | output | 1 | A bank was selected |
| dec_bank | output | 3 | Selected bank index |
| dec_fwd_local | output | 1 | System request passed on to the local bus |
| dec_miss | output | 1 | Strobed request produced no hit |

## Verification
Two functions can fall in the same cycle: a table write and a request decode. The bench provokes this by driving a write that clears bank 0's valid bit in the same cycle as a request that only bank 0 can satisfy. It expects that request to still hit bank 0, and the identical request one cycle later to miss. A second collision is a system request that matches a low-index system-owned bank and a higher-index local-owned bank at once. There, the bench expects the local-owned bank to be reported with forward set.

// File: rtl/bank_dec_pkg.sv
package bank_dec_pkg;
  typedef enum logic {
    OWN_SYS = 1'b0,
    OWN_LOC = 1'b1
  } owner_e;
endpackage

// File: rtl/bank_cfg_regs.sv
module bank_cfg_regs #(
  parameter int NB = 8,
  parameter int AW = 32,
  localparam int IW = $clog2(NB)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [IW-1:0]          widx,
  input  logic [AW-1:0]          wbase,
  input  logic [AW-1:0]          wmask,
  input  logic                   wvalid,
  input  logic                   wowner,
  output logic [NB-1:0][AW-1:0]  base_o,
  output logic [NB-1:0][AW-1:0]  mask_o,
  output logic [NB-1:0]          valid_o,
  output logic [NB-1:0]          owner_o
);
  for (genvar i = 0; i < NB; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        base_o[i]  <= '0;
        mask_o[i]  <= '0;
        valid_o[i] <= 1'b0;
        owner_o[i] <= 1'b0;
      end else if (we && widx == IW'(i)) begin
        base_o[i]  <= wbase;
        mask_o[i]  <= wmask;
        valid_o[i] <= wvalid;
        owner_o[i] <= wowner;
      end
    end
  end

  // R8: the cycle after reset, no bank is valid
  a_r8_reset_clears: assert property (@(posedge clk) $past(rst) |-> valid_o == '0);
endmodule

// File: rtl/bank_match.sv
module bank_match #(
  parameter int NB = 8,
  parameter int AW = 32
) (
  input  logic [AW-1:0]          addr,
  input  logic [NB-1:0][AW-1:0]  base,
  input  logic [NB-1:0][AW-1:0]  mask,
  input  logic [NB-1:0]          valid,
  output logic [NB-1:0]          match
);
  for (genvar i = 0; i < NB; i++) begin : g_cmp
    assign match[i] = valid[i] && ((addr & mask[i]) == (base[i] & mask[i]));
  end
endmodule

// File: rtl/bank_prio.sv
module bank_prio #(
  parameter int NB = 8,
  localparam int IW = $clog2(NB)
) (
  input  logic [NB-1:0] match,
  input  logic [NB-1:0] owner,
  input  logic          from_local,
  output logic          sel_hit,
  output logic [IW-1:0] sel_idx,
  output logic          sel_fwd
);
  logic [NB-1:0] loc_m;
  logic [IW-1:0] first_any, first_loc;

  assign loc_m = match & owner;

  always_comb begin
    first_any = '0;
    first_loc = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (match[i]) first_any = IW'(i);
      if (loc_m[i]) first_loc = IW'(i);
    end
  end

  always_comb begin
    sel_hit = 1'b0;
    sel_idx = '0;
    sel_fwd = 1'b0;
    if (|loc_m) begin
      sel_hit = 1'b1;
      sel_idx = first_loc;
      sel_fwd = !from_local;
    end else if (!from_local && |match) begin
      sel_hit = 1'b1;
      sel_idx = first_any;
    end
  end

  // R3: the reported bank is one that actually matched
  always_comb begin
    if (sel_hit === 1'b1) begin
      a_r3_sel_is_match: assert (match[sel_idx]);
    end
  end
endmodule

// File: rtl/bank_addr_decoder.sv
module bank_addr_decoder #(
  parameter int NB = 8,
  parameter int AW = 32,
  localparam int IW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_mask,
  input  logic          cfg_valid,
  input  logic          cfg_owner,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_from_local,
  output logic          dec_hit,
  output logic [IW-1:0] dec_bank,
  output logic          dec_fwd_local,
  output logic          dec_miss
);
  import bank_dec_pkg::*;

  logic [NB-1:0][AW-1:0] t_base, t_mask;
  logic [NB-1:0]         t_valid, t_owner, match;
  logic                  s_hit, s_fwd;
  logic [IW-1:0]         s_idx;

  bank_cfg_regs #(.NB(NB), .AW(AW)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .widx(cfg_idx),
    .wbase(cfg_base), .wmask(cfg_mask), .wvalid(cfg_valid),
    .wowner(cfg_owner == OWN_LOC),
    .base_o(t_base), .mask_o(t_mask), .valid_o(t_valid), .owner_o(t_owner)
  );

  bank_match #(.NB(NB), .AW(AW)) u_match (
    .addr(req_addr), .base(t_base), .mask(t_mask), .valid(t_valid),
    .match(match)
  );

  bank_prio #(.NB(NB)) u_prio (
    .match(match), .owner(t_owner), .from_local(req_from_local),
    .sel_hit(s_hit), .sel_idx(s_idx), .sel_fwd(s_fwd)
  );

  always_ff @(posedge clk) begin
    if (rst || !req_valid) begin
      dec_hit       <= 1'b0;
      dec_bank      <= '0;
      dec_fwd_local <= 1'b0;
      dec_miss      <= 1'b0;
    end else begin
      dec_hit       <= s_hit;
      dec_bank      <= s_idx;
      dec_fwd_local <= s_fwd;
      dec_miss      <= !s_hit;
    end
  end

  a_r7_hit_miss_excl: assert property (@(posedge clk) disable iff (rst)
    !(dec_hit && dec_miss));
  a_r1_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    (dec_hit || dec_miss) |-> $past(req_valid));
  a_r4_fwd_from_sys: assert property (@(posedge clk) disable iff (rst)
    dec_fwd_local |-> (dec_hit && !$past(req_from_local)));
  a_r9_idx_zero: assert property (@(posedge clk) disable iff (rst)
    !dec_hit |-> (dec_bank == '0 && !dec_fwd_local));
endmodule

// File: tb/tb_bank_addr_decoder.sv
`timescale 1ns/1ps
module tb_bank_addr_decoder;
  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 0, cfg_valid = 0, cfg_owner = 0;
  logic [2:0] cfg_idx = '0;
  logic [31:0] cfg_base = '0, cfg_mask = '0, req_addr = '0;
  logic req_valid = 0, req_from_local = 0;
  logic dec_hit, dec_fwd_local, dec_miss;
  logic [2:0] dec_bank;

  always #2 clk = ~clk;

  bank_addr_decoder dut (.*);

  typedef struct packed { logic hit; logic [2:0] bank; logic fwd; logic miss; } exp_t;
  exp_t  q_exp[$];
  string q_tag[$];
  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_base[8], m_mask[8];
  logic        m_val[8], m_own[8];

  function automatic exp_t model(logic rv, logic [31:0] a, logic fl);
    exp_t e = '0;
    int lo = -1, an = -1;
    if (!rv) return e;
    for (int i = 7; i >= 0; i--) begin
      if (m_val[i] && ((a & m_mask[i]) == (m_base[i] & m_mask[i]))) begin
        an = i;
        if (m_own[i]) lo = i;
      end
    end
    if (lo >= 0) begin e.hit = 1; e.bank = 3'(lo); e.fwd = !fl; end
    else if (!fl && an >= 0) begin e.hit = 1; e.bank = 3'(an); end
    else e.miss = 1;
    return e;
  endfunction

  task automatic drive(input logic we, input logic [2:0] wi, input logic [31:0] wb,
                       input logic [31:0] wm, input logic wv, input logic wo,
                       input logic rv, input logic [31:0] a, input logic fl,
                       input string tag);
    @(negedge clk);
    cfg_we = we; cfg_idx = wi; cfg_base = wb; cfg_mask = wm;
    cfg_valid = wv; cfg_owner = wo;
    req_valid = rv; req_addr = a; req_from_local = fl;
    q_exp.push_back(model(rv, a, fl));
    q_tag.push_back(tag);
    if (we) begin m_base[wi] = wb; m_mask[wi] = wm; m_val[wi] = wv; m_own[wi] = wo; end
  endtask

  task automatic wr(input logic [2:0] i, input logic [31:0] b, input logic [31:0] m,
                    input logic v, input logic o);
    drive(1, i, b, m, v, o, 0, '0, 0, "R1");
  endtask

  task automatic rq(input logic [31:0] a, input logic fl, input string tag);
    drive(0, '0, '0, '0, 0, 0, 1, a, fl, tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst && q_exp.size() > 0) begin
      exp_t e, g;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      g = '{dec_hit, dec_bank, dec_fwd_local, dec_miss};
      checks++;
      if (g !== e) begin
        fails++;
        $display("FAIL %s: got hit=%b bank=%0d fwd=%b miss=%b expected hit=%b bank=%0d fwd=%b miss=%b",
                 t, g.hit, g.bank, g.fwd, g.miss, e.hit, e.bank, e.fwd, e.miss);
      end
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_base[i] = '0; m_mask[i] = '0; m_val[i] = 0; m_own[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({dec_hit, dec_bank, dec_fwd_local, dec_miss} !== 6'b0) begin
      fails++;
      $display("FAIL R1 reset: got %b expected 000000",
               {dec_hit, dec_bank, dec_fwd_local, dec_miss});
    end
    @(negedge clk); rst = 0;
    rq(32'h1234_5678, 0, "R8 empty table misses");
    wr(2, 32'h1000_0000, 32'hF000_0000, 1, 0);
    rq(32'h1234_5678, 0, "R2 mask match");
    rq(32'h2000_0000, 0, "R7 miss");
    wr(5, 32'h1000_0000, 32'hFF00_0000, 1, 0);
    rq(32'h1000_0004, 0, "R3 lowest index");
    rq(32'h1200_0000, 0, "R2 partial overlap");
    wr(6, 32'h1000_0000, 32'hFFFF_0000, 1, 1);
    rq(32'h1000_1234, 0, "R5 local beats lower sys");
    rq(32'h1000_1234, 1, "R6 local to local bank");
    rq(32'h1100_0000, 1, "R6 local to sys bank dropped");
    drive(0, '0, '0, '0, 0, 0, 0, 32'h1000_1234, 0, "R1 no strobe");
    wr(0, 32'h0, 32'h0, 0, 0);
    rq(32'h9000_0000, 0, "R2 invalid never matches");
    wr(0, 32'h0, 32'h0, 1, 0);
    rq(32'h9000_0000, 0, "R3 catch-all bank 0");
    rq(32'h1000_1234, 0, "R5 local beats bank 0");
    drive(1, 3'd0, 32'h0, 32'h0, 0, 0, 1, 32'h9000_0000, 0, "R8 same-cycle write old table");
    rq(32'h9000_0000, 0, "R8 write visible next cycle");
    wr(7, 32'hA000_0000, 32'hF000_0000, 1, 1);
    rq(32'hA000_0010, 0, "R4 sys forwarded to local");
    rq(32'hA000_0010, 1, "R6 local hit no forward");
    rq(32'hB000_0000, 1, "R9 miss bank zero");
    drive(0, '0, '0, '0, 0, 0, 0, '0, 0, "R1 idle");
    while (q_exp.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired: got hang expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule